// File: doc/BRIEF.md
# Processor Status Word Register with Condition Check

This block keeps the 32-bit status word of a processor core. The word carries four arithmetic condition flags at the top (negative, zero, carry, overflow), two interrupt mask bits, an instruction-set select bit and a 5-bit operating-mode field at the bottom. Execution logic changes the word in one of four ways, all of which take effect at the next rising clock edge:

- a whole-word load;
- a mode-field load;
- a flag-group update that rewrites two, three or four of the top flags;
- a write of one named status bit.

The block also answers, every cycle, whether a 4-bit condition code is satisfied by the flags as currently stored. The issue stage uses that answer to decide whether a conditional instruction executes. Computing the flags from results is done elsewhere. Saving the word when an exception is taken is also outside this block.

Top module: `status_word_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, `status_word` becomes `RESET_WORD` (default 0x000000D3: both interrupt masks set, mode field 5'b10011) at that edge.
- R2: With `full_we` high, `status_word` takes all 32 bits of `full_data` at the next edge.
- R3: With `mode_we` high (and `full_we` low), bits 4:0 take `mode_data` and bits 31:5 keep their value.
- R4: A flag-group update with `grp_sel`=0 writes `grp_flags[3]` to bit 31 and `grp_flags[2]` to bit 30, and keeps bits 29:0.
- R5: A flag-group update with `grp_sel`=1 writes `grp_flags[3:1]` to bits 31:29, and keeps bits 28:0.
- R6: `grp_sel`=2 (separate flags) and `grp_sel`=3 (packed nibble) both copy `grp_flags[3:0]` unchanged to bits 31:28, with bit 3 to bit 31, and keep bits 27:0.
- R7: A single-bit write stores `bit_val` at the bit named by `bit_sel`: 0→31 (N), 1→30 (Z), 2→29 (C), 3→28 (V), 4→7 (IRQ mask), 5→6 (FIQ mask), 6→5 (instruction set). Code 7 changes nothing.
- R8: When several writes are requested together, only the highest one applies: whole word, then mode field, then flag group, then single bit.
- R9: Condition codes 0 to 7 pass on Z, !Z, C, !C, N, !N, V and !V respectively.
- R10: Condition codes 8 to 13 pass on (C and !Z), (!C or Z), (N==V), (N!=V), (!Z and N==V) and (Z or N!=V) respectively.
- R11: Condition code 14 always passes and condition code 15 never passes.
- R12: `cond_pass` is combinational from the stored word and `cond_code`. A write requested in a cycle changes neither `status_word` nor `cond_pass` until after the next edge.
- R13: With no write requested (or only a single-bit write with code 7), `status_word` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| full_we | input | 1 | Whole-word load request |
| full_data | input | 32 | Word for the whole-word load |
| mode_we | input | 1 | Mode-field load request |
| mode_data | input | 5 | New mode field |
| grp_we | input | 1 | Flag-group update request |
| grp_sel | input | 2 | Group: 0 NZ, 1 NZC, 2 NZCV, 3 packed NZCV |
| grp_flags | input | 4 | Flag values {N,Z,C,V} |
| bit_we | input | 1 | Single-bit write request |
| bit_sel | input | 3 | Which bit to write (see R7) |
| bit_val | input | 1 | Value for the single-bit write |
| cond_code | input | 4 | Condition code to evaluate |
| status_word | output | 32 | Stored status word |
| cond_pass | output | 1 | Condition code satisfied by stored flags |

## Verification
The bench first loads every one of the 16 flag combinations through the packed path and then sweeps all 16 condition codes against each. This separates codes that differ only in how they combine flags, such as GE against GT or HI against LS. Directed steps drive each write kind alone over a word of alternating bits, so a mask that keeps or takes one bit too many shows up. Further directed steps drive all four writes together, and then drop them one at a time, to expose a wrong priority. Random cycles then mix overlapping requests, including bit code 7, with random condition codes. Every step also checks just before the clock edge that a pending write has not yet reached the outputs.

// File: rtl/swu_pkg.sv
`timescale 1ns/1ps
// swu_pkg: shared constants and types for the status word unit.
// Assumes a 32-bit status word with the flags in its four top bits.
package swu_pkg;

    localparam int WORD_W   = 32;
    localparam int POS_N    = 31;
    localparam int POS_Z    = 30;
    localparam int POS_C    = 29;
    localparam int POS_V    = 28;
    localparam int POS_IRQM = 7;
    localparam int POS_FIQM = 6;
    localparam int POS_ISET = 5;
    localparam int FLAG_CNT = 4;

    // Flag-group selector values
    typedef enum logic [1:0] {
        GRP_NZ   = 2'd0,
        GRP_NZC  = 2'd1,
        GRP_NZCV = 2'd2,
        GRP_PACK = 2'd3
    } grp_sel_e;

    // Single-bit selector values
    typedef enum logic [2:0] {
        SEL_N    = 3'd0,
        SEL_Z    = 3'd1,
        SEL_C    = 3'd2,
        SEL_V    = 3'd3,
        SEL_IRQM = 3'd4,
        SEL_FIQM = 3'd5,
        SEL_ISET = 3'd6,
        SEL_NONE = 3'd7
    } bit_sel_e;

    // Flags in the order they sit in the word
    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    // Bit position named by a single-bit selector, -1 when none
    function automatic int bit_pos(input logic [2:0] sel);
        case (sel)
            SEL_N:    return POS_N;
            SEL_Z:    return POS_Z;
            SEL_C:    return POS_C;
            SEL_V:    return POS_V;
            SEL_IRQM: return POS_IRQM;
            SEL_FIQM: return POS_FIQM;
            SEL_ISET: return POS_ISET;
            default:  return -1;
        endcase
    endfunction

    // Number of top flags a group update rewrites
    function automatic logic [2:0] grp_take(input logic [1:0] sel);
        case (sel)
            GRP_NZ:  return 3'd2;
            GRP_NZC: return 3'd3;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/swu_group_merge.sv
`timescale 1ns/1ps
// swu_group_merge: builds the word that results from a flag-group update.
// It rewrites the top two, three or four flag bits from the supplied nibble
// and passes every other bit through. It assumes the flags occupy the top
// FLAG_CNT bits of the word. Purely combinational.
module swu_group_merge
    import swu_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0] cur_word,
    input  logic [1:0]   grp_sel,
    input  logic [3:0]   grp_flags,
    output logic [W-1:0] grp_word
);

    localparam int TOP = W - 1;

    logic [2:0] take_cnt;

    // Purpose: decode how many top flags the selected group covers
    always_comb begin
        take_cnt = grp_take(grp_sel);
    end

    // Purpose: per flag bit, choose new value or keep the stored one
    for (genvar j = 0; j < FLAG_CNT; j++) begin : g_flag
        assign grp_word[TOP-j] = (take_cnt > 3'(j)) ? grp_flags[FLAG_CNT-1-j]
                                                    : cur_word[TOP-j];
    end

    // Purpose: the lower status bits are never touched by a group update
    assign grp_word[TOP-FLAG_CNT:0] = cur_word[TOP-FLAG_CNT:0];

endmodule

// File: rtl/swu_bit_merge.sv
`timescale 1ns/1ps
// swu_bit_merge: builds the word that results from a single-bit write.
// The selector names one of seven status bits. Selector code 7 names none,
// and the word then passes through unchanged. Purely combinational.
module swu_bit_merge
    import swu_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0] cur_word,
    input  logic [2:0]   bit_sel,
    input  logic         bit_val,
    output logic [W-1:0] bit_word
);

    int target;

    // Purpose: translate the selector into a bit position
    always_comb begin
        target = bit_pos(bit_sel);
    end

    // Purpose: replace only the bit whose position matches the target
    for (genvar g = 0; g < W; g++) begin : g_bit
        assign bit_word[g] = (target == g) ? bit_val : cur_word[g];
    end

endmodule

// File: rtl/swu_next_word.sv
`timescale 1ns/1ps
// swu_next_word: picks the next status word from the four write kinds.
// Only the highest-priority request applies: whole word first, then mode
// field, then flag group, then single bit. With no request the current word
// is returned. It assumes the mode field sits in the lowest MODE_W bits.
module swu_next_word
    import swu_pkg::*;
#(
    parameter int W      = WORD_W,
    parameter int MODE_W = 5
) (
    input  logic [W-1:0]      cur_word,
    input  logic              full_we,
    input  logic [W-1:0]      full_data,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_data,
    input  logic              grp_we,
    input  logic [1:0]        grp_sel,
    input  logic [3:0]        grp_flags,
    input  logic              bit_we,
    input  logic [2:0]        bit_sel,
    input  logic              bit_val,
    output logic [W-1:0]      next_word
);

    logic [W-1:0] grp_word;
    logic [W-1:0] bit_word;
    logic [W-1:0] mode_word;

    swu_group_merge #(.W(W)) u_grp (
        .cur_word (cur_word),
        .grp_sel  (grp_sel),
        .grp_flags(grp_flags),
        .grp_word (grp_word)
    );

    swu_bit_merge #(.W(W)) u_bit (
        .cur_word(cur_word),
        .bit_sel (bit_sel),
        .bit_val (bit_val),
        .bit_word(bit_word)
    );

    // Purpose: mode load replaces the low field and keeps the rest
    assign mode_word = {cur_word[W-1:MODE_W], mode_data};

    // Purpose: fixed-priority choice among the write kinds
    always_comb begin
        if (full_we) begin
            next_word = full_data;
        end else if (mode_we) begin
            next_word = mode_word;
        end else if (grp_we) begin
            next_word = grp_word;
        end else if (bit_we) begin
            next_word = bit_word;
        end else begin
            next_word = cur_word;
        end
    end

endmodule

// File: rtl/swu_cond_eval.sv
`timescale 1ns/1ps
// swu_cond_eval: decides whether a 4-bit condition code passes on the given
// flags. Codes come in pairs. Bits 3:1 pick a base test, and bit 0 inverts
// it, so code 14 (always) and code 15 (never) also fall out of the pair
// scheme. Purely combinational.
module swu_cond_eval
    import swu_pkg::*;
(
    input  flags_t     flags,
    input  logic [3:0] cond_code,
    output logic       cond_pass
);

    logic base;

    // Purpose: evaluate the even member of each code pair
    always_comb begin
        case (cond_code[3:1])
            3'd0:    base = flags.z;
            3'd1:    base = flags.c;
            3'd2:    base = flags.n;
            3'd3:    base = flags.v;
            3'd4:    base = flags.c & ~flags.z;
            3'd5:    base = (flags.n == flags.v);
            3'd6:    base = ~flags.z & (flags.n == flags.v);
            default: base = 1'b1;
        endcase
    end

    // Purpose: the odd member of a pair is the inverse of the even one
    assign cond_pass = base ^ cond_code[0];

endmodule

// File: rtl/status_word_unit.sv
`timescale 1ns/1ps
// status_word_unit: holds the processor status word and reports whether a
// condition code passes on its flags. Writes take effect at the next rising
// edge, and the condition output follows the stored word. Reset is
// synchronous and active low. It assumes one clock domain, with all
// requests sampled at the rising edge.
module status_word_unit
    import swu_pkg::*;
#(
    parameter int          MODE_W     = 5,
    parameter logic [31:0] RESET_WORD = 32'h0000_00D3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              full_we,
    input  logic [31:0]       full_data,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_data,
    input  logic              grp_we,
    input  logic [1:0]        grp_sel,
    input  logic [3:0]        grp_flags,
    input  logic              bit_we,
    input  logic [2:0]        bit_sel,
    input  logic              bit_val,
    input  logic [3:0]        cond_code,
    output logic [31:0]       status_word,
    output logic              cond_pass
);

    localparam int W   = WORD_W;
    localparam int TOP = W - 1;

    logic [W-1:0] word_q;
    logic [W-1:0] word_d;
    flags_t       cur_flags;

    swu_next_word #(.W(W), .MODE_W(MODE_W)) u_next (
        .cur_word (word_q),
        .full_we  (full_we),
        .full_data(full_data),
        .mode_we  (mode_we),
        .mode_data(mode_data),
        .grp_we   (grp_we),
        .grp_sel  (grp_sel),
        .grp_flags(grp_flags),
        .bit_we   (bit_we),
        .bit_sel  (bit_sel),
        .bit_val  (bit_val),
        .next_word(word_d)
    );

    // Purpose: status word register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= RESET_WORD;
        end else begin
            word_q <= word_d;
        end
    end

    // Purpose: pick the four condition flags out of the stored word
    assign cur_flags = flags_t'(word_q[TOP:TOP-FLAG_CNT+1]);

    swu_cond_eval u_cond (
        .flags    (cur_flags),
        .cond_code(cond_code),
        .cond_pass(cond_pass)
    );

    assign status_word = word_q;

    AST_RESET_VALUE: assert property (@(posedge clk)
        !rst_n |=> status_word == RESET_WORD); // R1

    AST_FULL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        full_we |=> status_word == $past(full_data)); // R2

    AST_MODE_KEEPS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_we && mode_we) |=>
            (status_word[TOP:MODE_W] == $past(status_word[TOP:MODE_W]))
            && (status_word[MODE_W-1:0] == $past(mode_data))); // R3

    AST_NZ_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_we && !mode_we && grp_we && grp_sel == GRP_NZ) |=>
            status_word[TOP-2:0] == $past(status_word[TOP-2:0])); // R4

    AST_NZC_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_we && !mode_we && grp_we && grp_sel == GRP_NZC) |=>
            status_word[TOP-3:0] == $past(status_word[TOP-3:0])); // R5

    AST_PACK_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_we && !mode_we && grp_we && grp_sel[1]) |=>
            (status_word[TOP:TOP-3] == $past(grp_flags))
            && (status_word[TOP-4:0] == $past(status_word[TOP-4:0]))); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_we && !mode_we && !grp_we && (!bit_we || bit_sel == SEL_NONE))
            |=> $stable(status_word)); // R13

    AST_BIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_we && !mode_we && !grp_we && bit_we) |=>
            $countones(status_word ^ $past(status_word)) <= 1); // R7

    AST_COND_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_code == 4'hE) |-> cond_pass); // R11

    AST_COND_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_code == 4'hF) |-> !cond_pass); // R11

    AST_COND_EQ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_code == 4'h0) |-> (cond_pass == status_word[POS_Z])); // R9

endmodule

// File: tb/status_word_unit_tb.sv
`timescale 1ns/1ps
// Bench for status_word_unit. Directed corner steps are followed by
// fixed-seed random steps, all checked against a reference model.
module status_word_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        full_we;
    logic [31:0] full_data;
    logic        mode_we;
    logic [4:0]  mode_data;
    logic        grp_we;
    logic [1:0]  grp_sel;
    logic [3:0]  grp_flags;
    logic        bit_we;
    logic [2:0]  bit_sel;
    logic        bit_val;
    logic [3:0]  cond_code;
    logic [31:0] status_word;
    logic        cond_pass;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;
    logic [31:0] model;

    status_word_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .full_we(full_we), .full_data(full_data),
        .mode_we(mode_we), .mode_data(mode_data),
        .grp_we(grp_we), .grp_sel(grp_sel), .grp_flags(grp_flags),
        .bit_we(bit_we), .bit_sel(bit_sel), .bit_val(bit_val),
        .cond_code(cond_code),
        .status_word(status_word), .cond_pass(cond_pass)
    );

    always #5 clk = ~clk;

    function automatic bit cond_ref(input logic [31:0] w, input logic [3:0] c);
        bit n = w[31];
        bit z = w[30];
        bit cy = w[29];
        bit v = w[28];
        case (c)
            4'h0: return z;
            4'h1: return !z;
            4'h2: return cy;
            4'h3: return !cy;
            4'h4: return n;
            4'h5: return !n;
            4'h6: return v;
            4'h7: return !v;
            4'h8: return cy && !z;
            4'h9: return !cy || z;
            4'hA: return n == v;
            4'hB: return n != v;
            4'hC: return !z && (n == v);
            4'hD: return z || (n != v);
            4'hE: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] next_ref(input logic [31:0] w);
        logic [31:0] r = w;
        if (full_we) begin
            r = full_data;
        end else if (mode_we) begin
            r[4:0] = mode_data;
        end else if (grp_we) begin
            r[31] = grp_flags[3];
            r[30] = grp_flags[2];
            if (grp_sel != 2'd0) r[29] = grp_flags[1];
            if (grp_sel[1])      r[28] = grp_flags[0];
        end else if (bit_we) begin
            case (bit_sel)
                3'd0: r[31] = bit_val;
                3'd1: r[30] = bit_val;
                3'd2: r[29] = bit_val;
                3'd3: r[28] = bit_val;
                3'd4: r[7]  = bit_val;
                3'd5: r[6]  = bit_val;
                3'd6: r[5]  = bit_val;
                default: ;
            endcase
        end
        return r;
    endfunction

    function automatic string write_tag();
        if (full_we)  return (mode_we || grp_we || bit_we) ? "R8" : "R2";
        if (mode_we)  return (grp_we || bit_we) ? "R8" : "R3";
        if (grp_we) begin
            if (bit_we) return "R8";
            case (grp_sel)
                2'd0:    return "R4";
                2'd1:    return "R5";
                default: return "R6";
            endcase
        end
        if (bit_we && bit_sel != 3'd7) return "R7";
        return "R13";
    endfunction

    function automatic string cond_tag(input logic [3:0] c);
        if (c < 4'h8)  return "R9";
        if (c < 4'hE)  return "R10";
        return "R11";
    endfunction

    task automatic check_word(input string tag, input logic [31:0] exp);
        checks++;
        if (status_word !== exp) begin
            errors++;
            $display("FAIL %s status_word actual=%08h expected=%08h", tag, status_word, exp);
        end
    endtask

    task automatic check_cond(input string tag, input bit exp);
        checks++;
        if (cond_pass !== exp) begin
            errors++;
            $display("FAIL %s cond_pass code=%0h actual=%0b expected=%0b",
                     tag, cond_code, cond_pass, exp);
        end
    endtask

    task automatic clear_inputs();
        full_we = 0; full_data = '0; mode_we = 0; mode_data = '0;
        grp_we = 0; grp_sel = '0; grp_flags = '0;
        bit_we = 0; bit_sel = '0; bit_val = 0; cond_code = '0;
    endtask

    // Called at a falling edge with inputs already set: checks that nothing
    // moves before the edge, then checks the result after it.
    task automatic step();
        logic [31:0] exp_next;
        string tag;
        #1;
        check_word("R12", model);
        check_cond(cond_tag(cond_code), cond_ref(model, cond_code));
        exp_next = next_ref(model);
        tag = write_tag();
        @(posedge clk);
        @(negedge clk);
        check_word(tag, exp_next);
        model = exp_next;
        check_cond("R12", cond_ref(model, cond_code));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        clear_inputs();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_word("R1", 32'h0000_00D3);
        model = 32'h0000_00D3;
        rst_n = 1'b1;

        // R2 whole-word load of an alternating pattern
        clear_inputs(); full_we = 1; full_data = 32'hAAAA_AAAA; step();
        // R4, R5, R6 group updates against the pattern
        clear_inputs(); grp_we = 1; grp_sel = 2'd0; grp_flags = 4'b0101; step();
        clear_inputs(); full_we = 1; full_data = 32'h5555_5555; step();
        clear_inputs(); grp_we = 1; grp_sel = 2'd1; grp_flags = 4'b1011; step();
        clear_inputs(); grp_we = 1; grp_sel = 2'd2; grp_flags = 4'b0110; step();
        clear_inputs(); grp_we = 1; grp_sel = 2'd3; grp_flags = 4'b1001; step();
        // R3 mode load
        clear_inputs(); mode_we = 1; mode_data = 5'b01010; step();
        // R7 every single-bit code, set then clear
        for (int s = 0; s < 8; s++) begin
            clear_inputs(); bit_we = 1; bit_sel = 3'(s); bit_val = 1; step();
            clear_inputs(); bit_we = 1; bit_sel = 3'(s); bit_val = 0; step();
        end
        // R8 priority: all at once, then drop the winner each time
        clear_inputs(); full_we = 1; full_data = 32'h1234_5678; mode_we = 1;
        mode_data = 5'h1F; grp_we = 1; grp_flags = 4'hF; grp_sel = 2'd2;
        bit_we = 1; bit_sel = 3'd4; bit_val = 1; step();
        full_we = 0; step();
        mode_we = 0; step();
        grp_we = 0; step();
        // R13 idle hold
        clear_inputs(); step();

        // R9 R10 R11 every flag combination against every code
        for (int f = 0; f < 16; f++) begin
            clear_inputs(); grp_we = 1; grp_sel = 2'd3; grp_flags = 4'(f); step();
            for (int c = 0; c < 16; c++) begin
                clear_inputs(); cond_code = 4'(c); step();
            end
        end

        // Random mix of overlapping requests
        for (int i = 0; i < 1500; i++) begin
            full_we   = ($urandom % 8) == 0;
            full_data = $urandom;
            mode_we   = ($urandom % 6) == 0;
            mode_data = 5'($urandom);
            grp_we    = ($urandom % 3) == 0;
            grp_sel   = 2'($urandom);
            grp_flags = 4'($urandom);
            bit_we    = ($urandom % 2) == 0;
            bit_sel   = 3'($urandom);
            bit_val   = 1'($urandom);
            cond_code = 4'($urandom);
            step();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule